// File: doc/BRIEF.md
# Shared-Capacity Multithread Skid Buffer

This block sits at the input of a pipeline stage that interleaves several hardware threads. Each thread has its own queue, kept in order. All the queues draw on one pool of entries, and that pool holds as many entries as the stage is wide. Every entry carries a thread identifier, a sequence number and an opaque payload. The previous stage can present several entries per cycle on parallel lanes. Each cycle the stage names one thread. The buffer shows that thread's queue as a window with the oldest entry first. The stage answers with a per-slot completion vector. The buffer then retires the completed prefix of the window, up to the stage width.

The buffer reports its free capacity. It also combines that figure with the number of entries the sender already has in flight and tells the sender whether it may launch another one. A later stage can squash a thread younger than a given sequence number. Entries that arrive already marked as killed are dropped at the door. The block also exports per-thread empty and blocked flags and a registered total occupancy.

Top module: `mt_skid_pool`

## Requirements
- R1: `total_cnt` is a register holding the sum of all thread queue lengths. `free_slots` equals STAGE_W minus `total_cnt`, and `total_cnt` never exceeds STAGE_W.
- R2: `send_ok` is high exactly when `free_slots` is strictly greater than `inflight`.
- R3: An incoming lane with `in_kill` set is never stored. Occupancy and every queue are left as they were by that lane.
- R4: Each thread's queue is first-in first-out. Lanes presented in the same cycle are stored in lane order, lane 0 first. `win_*` shows the queue of thread `iss_tid`, with its oldest entry at slot 0, and `win_vld` is a contiguous run of ones from bit 0.
- R5: With `iss_en` high, `iss_cnt` is the length of the run of valid window slots from slot 0 whose `iss_done` bit is set, at most STAGE_W. Those entries are gone from the queue after the next clock edge. With `iss_en` low, `iss_cnt` is 0.
- R6: Issue halts at the first valid slot whose done bit is clear. Completed entries behind that slot are not issued.
- R7: A squash for thread T with bound S removes every stored entry of T whose sequence number is above S, using an unsigned comparison. Entries of T at or below S stay, in their order. Other threads are untouched.
- R8: A squash is also applied to entries for the same thread that arrive in the squash cycle.
- R9: `thr_blocked[t]` rises after a cycle in which thread t issued and still held stored entries afterwards. It stays high until the queue of t is empty, and it is then cleared. `thr_empty[t]` is high when thread t holds no entries.
- R10: After reset, all queues are empty: `total_cnt` is 0, `free_slots` is STAGE_W, every empty flag is set and every blocked flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | LANES | Incoming lane valid |
| in_kill | input | LANES | Incoming lane already killed |
| in_tid | input | LANES*TID_W | Thread of each lane |
| in_seq | input | LANES*SEQ_W | Sequence number of each lane |
| in_pay | input | LANES*PAY_W | Payload of each lane |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread to squash |
| sq_seq | input | SEQ_W | Youngest sequence number kept |
| iss_en | input | 1 | Issue enable |
| iss_tid | input | TID_W | Thread selected for window and issue |
| iss_done | input | STAGE_W | Per-slot completion of the window |
| inflight | input | CNT_W | Entries already travelling toward the buffer |
| win_vld | output | STAGE_W | Window slot valid |
| win_seq | output | STAGE_W*SEQ_W | Window sequence numbers |
| win_pay | output | STAGE_W*PAY_W | Window payloads |
| iss_cnt | output | CNT_W | Entries issued this cycle |
| free_slots | output | CNT_W | Unused shared capacity |
| send_ok | output | 1 | Sender may launch one more entry |
| total_cnt | output | CNT_W | Registered total occupancy |
| thr_empty | output | NUM_THREADS | Per-thread empty flag |
| thr_blocked | output | NUM_THREADS | Per-thread blocked flag |

## Verification
The bench uses the default parameters: two threads, a stage width of four, two input lanes, 8-bit sequence numbers and 16-bit payloads. Four entries are enough to fill the shared pool with one thread while the other thread holds a single entry. That lets the bench drive the credit signal to zero free slots and check it. Two lanes let a killed entry and a valid one arrive together, and let a squash meet two fresh arrivals in the same cycle. A four-deep window is enough to show an issue run that stops on a clear done bit with completed slots behind it, and a full-width issue that empties a queue and clears its blocked flag.

// File: rtl/mtsk_pkg.sv
package mtsk_pkg;

  // bits needed to name one of n threads (at least one)
  function automatic int id_bits(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // bits needed to hold a count from 0 to n
  function automatic int cnt_bits(int n);
    return $clog2(n + 1);
  endfunction

  function automatic int sat_to(int v, int lim);
    return (v > lim) ? lim : v;
  endfunction

endpackage

// File: rtl/mtsk_credit.sv
module mtsk_credit #(
  parameter int STAGE_W = 4,
  parameter int CNT_W   = 3
) (
  input  logic [CNT_W-1:0] total,
  input  logic [CNT_W-1:0] inflight,
  output logic [CNT_W-1:0] free_slots,
  output logic             send_ok
);
  always_comb begin
    if (int'(total) >= STAGE_W) free_slots = '0;
    else                        free_slots = CNT_W'(STAGE_W - int'(total));
    send_ok = (free_slots > inflight);
  end
endmodule

// File: rtl/mtsk_issue_sel.sv
module mtsk_issue_sel #(
  parameter int STAGE_W = 4,
  parameter int CNT_W   = 3
) (
  input  logic               en,
  input  logic [CNT_W-1:0]   avail,
  input  logic [STAGE_W-1:0] done,
  output logic [CNT_W-1:0]   pop_n
);
  always_comb begin
    logic run;
    run   = en;
    pop_n = '0;
    for (int i = 0; i < STAGE_W; i++) begin
      if (run && (CNT_W'(i) < avail) && done[i]) pop_n = pop_n + 1'b1;
      else                                      run   = 1'b0;
    end
  end
endmodule

// File: rtl/mtsk_thread_q.sv
module mtsk_thread_q #(
  parameter int DEPTH = 4,
  parameter int LANES = 2,
  parameter int SEQ_W = 8,
  parameter int PAY_W = 16,
  parameter int TID_W = 1,
  parameter int MY_ID = 0,
  parameter int CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES-1:0]       in_valid,
  input  logic [LANES-1:0]       in_kill,
  input  logic [LANES*TID_W-1:0] in_tid,
  input  logic [LANES*SEQ_W-1:0] in_seq,
  input  logic [LANES*PAY_W-1:0] in_pay,
  input  logic                   sq_valid,
  input  logic [TID_W-1:0]       sq_tid,
  input  logic [SEQ_W-1:0]       sq_seq,
  input  logic                   is_iss,
  input  logic [CNT_W-1:0]       pop_n,
  output logic [DEPTH*SEQ_W-1:0] q_seq,
  output logic [DEPTH*PAY_W-1:0] q_pay,
  output logic [CNT_W-1:0]       cnt_q,
  output logic [CNT_W-1:0]       cnt_n,
  output logic                   blk_q
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0][SEQ_W-1:0] seq_r, seq_n;
  logic [DEPTH-1:0][PAY_W-1:0] pay_r, pay_n;
  logic                        sq_hit;
  logic [CNT_W-1:0]            rem;
  logic                        blk_n;

  assign sq_hit = sq_valid && (sq_tid == TID_W'(MY_ID));
  assign rem    = cnt_q - pop_n;

  // survivors of issue and squash, then arrivals, packed toward slot 0
  always_comb begin
    int k;
    k     = 0;
    seq_n = '0;
    pay_n = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if ((CNT_W'(i) >= pop_n) && (CNT_W'(i) < cnt_q) &&
          !(sq_hit && (seq_r[i] > sq_seq))) begin
        if (k < DEPTH) begin
          seq_n[k[IDX_W-1:0]] = seq_r[i];
          pay_n[k[IDX_W-1:0]] = pay_r[i];
        end
        k++;
      end
    end
    for (int l = 0; l < LANES; l++) begin
      if (in_valid[l] && !in_kill[l] &&
          (in_tid[l*TID_W +: TID_W] == TID_W'(MY_ID)) &&
          !(sq_hit && (in_seq[l*SEQ_W +: SEQ_W] > sq_seq))) begin
        if (k < DEPTH) begin
          seq_n[k[IDX_W-1:0]] = in_seq[l*SEQ_W +: SEQ_W];
          pay_n[k[IDX_W-1:0]] = in_pay[l*PAY_W +: PAY_W];
        end
        k++;
      end
    end
    cnt_n = CNT_W'(mtsk_pkg::sat_to(k, DEPTH));
  end

  always_comb begin
    if (cnt_n == '0)                blk_n = 1'b0;
    else if (is_iss && rem != '0)   blk_n = 1'b1;
    else                            blk_n = blk_q;
  end

  // payload storage is not reset
  always_ff @(posedge clk) begin
    seq_r <= seq_n;
    pay_r <= pay_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      blk_q <= blk_n;
    end
  end

  assign q_seq = seq_r;
  assign q_pay = pay_r;
endmodule

// File: rtl/mt_skid_pool.sv
module mt_skid_pool #(
  parameter int NUM_THREADS = 2,
  parameter int STAGE_W     = 4,
  parameter int LANES       = 2,
  parameter int SEQ_W       = 8,
  parameter int PAY_W       = 16,
  parameter int TID_W       = mtsk_pkg::id_bits(NUM_THREADS),
  parameter int CNT_W       = mtsk_pkg::cnt_bits(STAGE_W)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [LANES-1:0]         in_valid,
  input  logic [LANES-1:0]         in_kill,
  input  logic [LANES*TID_W-1:0]   in_tid,
  input  logic [LANES*SEQ_W-1:0]   in_seq,
  input  logic [LANES*PAY_W-1:0]   in_pay,
  input  logic                     sq_valid,
  input  logic [TID_W-1:0]         sq_tid,
  input  logic [SEQ_W-1:0]         sq_seq,
  input  logic                     iss_en,
  input  logic [TID_W-1:0]         iss_tid,
  input  logic [STAGE_W-1:0]       iss_done,
  input  logic [CNT_W-1:0]         inflight,
  output logic [STAGE_W-1:0]       win_vld,
  output logic [STAGE_W*SEQ_W-1:0] win_seq,
  output logic [STAGE_W*PAY_W-1:0] win_pay,
  output logic [CNT_W-1:0]         iss_cnt,
  output logic [CNT_W-1:0]         free_slots,
  output logic                     send_ok,
  output logic [CNT_W-1:0]         total_cnt,
  output logic [NUM_THREADS-1:0]   thr_empty,
  output logic [NUM_THREADS-1:0]   thr_blocked
);
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [STAGE_W*SEQ_W-1:0] seq_all [NUM_THREADS];
  logic [STAGE_W*PAY_W-1:0] pay_all [NUM_THREADS];
  logic [CNT_W-1:0]         cnt_r   [NUM_THREADS];
  logic [CNT_W-1:0]         cnt_nx  [NUM_THREADS];
  logic [NUM_THREADS-1:0]   blk_r;
  logic [NUM_THREADS-1:0]   empty_q;
  logic [CNT_W-1:0]         cnt_sel;
  logic [CNT_W-1:0]         pop_sel;
  logic [CNT_W-1:0]         tot_q, tot_n;

  generate
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
      logic             mine;
      logic [CNT_W-1:0] pop_t;
      assign mine  = iss_en && (iss_tid == TID_W'(t));
      assign pop_t = mine ? pop_sel : '0;

      mtsk_thread_q #(
        .DEPTH(STAGE_W), .LANES(LANES), .SEQ_W(SEQ_W), .PAY_W(PAY_W),
        .TID_W(TID_W), .MY_ID(t), .CNT_W(CNT_W)
      ) u_q (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_kill(in_kill), .in_tid(in_tid),
        .in_seq(in_seq), .in_pay(in_pay),
        .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
        .is_iss(mine), .pop_n(pop_t),
        .q_seq(seq_all[t]), .q_pay(pay_all[t]),
        .cnt_q(cnt_r[t]), .cnt_n(cnt_nx[t]), .blk_q(blk_r[t])
      );
    end
  endgenerate

  // window of the selected thread
  always_comb begin
    cnt_sel = '0;
    win_seq = '0;
    win_pay = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (iss_tid == TID_W'(t)) begin
        cnt_sel = cnt_r[t];
        win_seq = seq_all[t];
        win_pay = pay_all[t];
      end
    end
    for (int i = 0; i < STAGE_W; i++) win_vld[i] = (CNT_W'(i) < cnt_sel);
  end

  mtsk_issue_sel #(.STAGE_W(STAGE_W), .CNT_W(CNT_W)) u_iss (
    .en(iss_en), .avail(cnt_sel), .done(iss_done), .pop_n(pop_sel)
  );
  assign iss_cnt = pop_sel;

  always_comb begin
    int s;
    s = 0;
    for (int t = 0; t < NUM_THREADS; t++) s += int'(cnt_nx[t]);
    tot_n = CNT_W'(mtsk_pkg::sat_to(s, CNT_MAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tot_q   <= '0;
      empty_q <= '1;
    end else begin
      tot_q <= tot_n;
      for (int t = 0; t < NUM_THREADS; t++) empty_q[t] <= (cnt_nx[t] == '0);
    end
  end

  mtsk_credit #(.STAGE_W(STAGE_W), .CNT_W(CNT_W)) u_cred (
    .total(tot_q), .inflight(inflight), .free_slots(free_slots), .send_ok(send_ok)
  );

  assign total_cnt   = tot_q;
  assign thr_empty   = empty_q;
  assign thr_blocked = blk_r;
endmodule

// File: rtl/mtsk_chk.sv
module mtsk_chk #(
  parameter int NUM_THREADS = 2,
  parameter int STAGE_W     = 4,
  parameter int LANES       = 2,
  parameter int CNT_W       = 3
) (
  input logic                   clk,
  input logic                   rst,
  input logic [LANES-1:0]       in_valid,
  input logic                   sq_valid,
  input logic                   iss_en,
  input logic [CNT_W-1:0]       iss_cnt,
  input logic [STAGE_W-1:0]     win_vld,
  input logic [CNT_W-1:0]       total_cnt,
  input logic [NUM_THREADS-1:0] thr_empty,
  input logic [NUM_THREADS-1:0] thr_blocked
);
  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    int'(total_cnt) <= STAGE_W);

  // R1
  growth_bound_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> int'(total_cnt) <= int'($past(total_cnt)) + LANES);

  // R4
  window_packed_chk: assert property (@(posedge clk) disable iff (rst)
    (win_vld & (win_vld + 1'b1)) == '0);

  // R5
  issue_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !iss_en |-> iss_cnt == '0);

  // R5
  issue_in_window_chk: assert property (@(posedge clk) disable iff (rst)
    int'(iss_cnt) <= $countones(win_vld));

  // R7
  squash_shrinks_chk: assert property (@(posedge clk) disable iff (rst)
    (sq_valid && in_valid == '0 && !iss_en) |=> total_cnt <= $past(total_cnt));

  generate
    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_blk
      // R9
      blocked_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
        thr_blocked[t] |-> !thr_empty[t]);
    end
  endgenerate
endmodule

bind mt_skid_pool mtsk_chk #(
  .NUM_THREADS(NUM_THREADS), .STAGE_W(STAGE_W), .LANES(LANES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .sq_valid(sq_valid),
  .iss_en(iss_en), .iss_cnt(iss_cnt), .win_vld(win_vld),
  .total_cnt(total_cnt), .thr_empty(thr_empty), .thr_blocked(thr_blocked)
);

// File: tb/test_mt_skid_pool.sv
`timescale 1ns/1ps
module test_mt_skid_pool;
  localparam int NT = 2, SW = 4, LN = 2, SQW = 8, PW = 16, TW = 1, CW = 3;

  logic clk = 1'b0, rst = 1'b1;
  logic [LN-1:0] in_valid, in_kill;
  logic [LN*TW-1:0] in_tid;
  logic [LN*SQW-1:0] in_seq;
  logic [LN*PW-1:0] in_pay;
  logic sq_valid, iss_en;
  logic [TW-1:0] sq_tid, iss_tid;
  logic [SQW-1:0] sq_seq;
  logic [SW-1:0] iss_done, win_vld;
  logic [CW-1:0] inflight, iss_cnt, free_slots, total_cnt;
  logic [SW*SQW-1:0] win_seq;
  logic [SW*PW-1:0] win_pay;
  logic send_ok;
  logic [NT-1:0] thr_empty, thr_blocked;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mt_skid_pool i_mt_skid_pool (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kill(in_kill),
    .in_tid(in_tid), .in_seq(in_seq), .in_pay(in_pay),
    .sq_valid(sq_valid), .sq_tid(sq_tid), .sq_seq(sq_seq),
    .iss_en(iss_en), .iss_tid(iss_tid), .iss_done(iss_done),
    .inflight(inflight), .win_vld(win_vld), .win_seq(win_seq),
    .win_pay(win_pay), .iss_cnt(iss_cnt), .free_slots(free_slots),
    .send_ok(send_ok), .total_cnt(total_cnt), .thr_empty(thr_empty),
    .thr_blocked(thr_blocked)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_in();
    in_valid = '0; in_kill = '0; in_tid = '0; in_seq = '0; in_pay = '0;
    sq_valid = 0; sq_tid = '0; sq_seq = '0;
    iss_en = 0; iss_done = '0; inflight = '0;
  endtask

  task automatic put(int l, int tid, int seq, int pay, bit kill);
    in_valid[l] = 1'b1;
    in_kill[l]  = kill;
    in_tid[l*TW +: TW]   = TW'(tid);
    in_seq[l*SQW +: SQW] = SQW'(seq);
    in_pay[l*PW +: PW]   = PW'(pay);
  endtask

  // apply driven inputs at one edge, return at the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    idle_in();
  endtask

  function automatic int wseq(int i);
    return int'(win_seq[i*SQW +: SQW]);
  endfunction

  task automatic t_reset();
    iss_tid = 0;
    #1;
    chk("R10 total", int'(total_cnt), 0);
    chk("R10 free", int'(free_slots), SW);
    chk("R10 empty", int'(thr_empty), 3);
    chk("R10 blocked", int'(thr_blocked), 0);
    chk("R10 window", int'(win_vld), 0);
  endtask

  task automatic t_enqueue_credit();
    put(0, 0, 10, 100, 0); put(1, 1, 20, 200, 0);
    step();
    chk("R1 total two", int'(total_cnt), 2);
    chk("R1 free two", int'(free_slots), 2);
    chk("R9 empty flags", int'(thr_empty), 0);
    inflight = 1; #1;
    chk("R2 credit one in flight", int'(send_ok), 1);
    inflight = 2; #1;
    chk("R2 credit two in flight", int'(send_ok), 0);
    inflight = 0;
    put(0, 0, 11, 101, 0); put(1, 0, 12, 102, 0);
    step();
    iss_tid = 0; #1;
    chk("R1 total full", int'(total_cnt), 4);
    chk("R2 credit when full", int'(send_ok), 0);
    chk("R4 window valid", int'(win_vld), 7);
    chk("R4 order slot0", wseq(0), 10);
    chk("R4 order slot1 lane0", wseq(1), 11);
    chk("R4 order slot2 lane1", wseq(2), 12);
    chk("R4 payload slot0", int'(win_pay[0 +: PW]), 100);
  endtask

  task automatic t_issue();
    iss_tid = 0; iss_en = 1; iss_done = 4'b1101; #1;
    chk("R5 issue count prefix", int'(iss_cnt), 1);
    step();
    iss_tid = 0; #1;
    chk("R5 total after issue", int'(total_cnt), 3);
    chk("R5 new head", wseq(0), 11);
    chk("R9 blocked set", int'(thr_blocked), 1);
    iss_en = 1; iss_done = 4'b1111; #1;
    chk("R5 issue limited by queue", int'(iss_cnt), 2);
    step();
    #1;
    chk("R5 total after drain", int'(total_cnt), 1);
    chk("R9 empty after drain", int'(thr_empty[0]), 1);
    chk("R9 blocked cleared", int'(thr_blocked[0]), 0);
  endtask

  task automatic t_stall_first();
    iss_tid = 1; iss_en = 1; iss_done = 4'b1110; #1;
    chk("R6 halt on first not done", int'(iss_cnt), 0);
    step();
    iss_tid = 1; #1;
    chk("R9 blocked with zero issue", int'(thr_blocked[1]), 1);
    chk("R6 nothing removed", int'(total_cnt), 1);
    iss_en = 0; iss_done = 4'b1111; #1;
    chk("R5 disabled issue", int'(iss_cnt), 0);
  endtask

  task automatic t_kill();
    put(0, 1, 21, 210, 1); put(1, 1, 99, 990, 1);
    step();
    iss_tid = 1; #1;
    chk("R3 killed not counted", int'(total_cnt), 1);
    chk("R3 killed not in window", int'(win_vld), 1);
    chk("R3 head intact", wseq(0), 20);
  endtask

  task automatic t_squash();
    put(0, 1, 22, 220, 0); put(1, 1, 25, 250, 0);
    step();
    put(0, 1, 23, 230, 0);
    step();
    iss_tid = 1; #1;
    chk("R4 four in thread", int'(win_vld), 15);
    sq_valid = 1; sq_tid = 1; sq_seq = 22;
    step();
    iss_tid = 1; #1;
    chk("R7 survivors", int'(win_vld), 3);
    chk("R7 keep older", wseq(0), 20);
    chk("R7 keep equal", wseq(1), 22);
    chk("R7 total", int'(total_cnt), 2);
  endtask

  task automatic t_squash_enq();
    put(0, 1, 30, 300, 0); put(1, 1, 21, 211, 0);
    sq_valid = 1; sq_tid = 1; sq_seq = 25;
    step();
    iss_tid = 1; #1;
    chk("R8 incoming filtered", int'(win_vld), 7);
    chk("R8 kept arrival", wseq(2), 21);
    chk("R8 total", int'(total_cnt), 3);
  endtask

  task automatic t_full_issue();
    put(0, 1, 31, 310, 0);
    step();
    iss_tid = 1; iss_en = 1; iss_done = 4'b1111; #1;
    chk("R5 full width issue", int'(iss_cnt), 4);
    step();
    #1;
    chk("R5 total zero", int'(total_cnt), 0);
    chk("R9 empty both", int'(thr_empty), 3);
    chk("R9 blocked cleared on empty", int'(thr_blocked), 0);
    chk("R1 free restored", int'(free_slots), SW);
  endtask

  initial begin
    idle_in();
    iss_tid = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_enqueue_credit();
    t_issue();
    t_stall_first();
    t_kill();
    t_squash();
    t_squash_enq();
    t_full_issue();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule